// File: doc/BRIEF.md
# Converter Sample Formatter and Bus Splitter

This block sits between a 12-bit pipelined converter core and the output pins. On each sample clock it may receive one raw sample, an offset-binary value from the core, along with two flags: one that shows the analog input was above positive full scale, and one that shows it was below negative full scale. The block clamps out-of-range samples to the end codes, sets a per-sample overflow bit, and recodes the value to two's complement if that format is selected.

The formatted stream then leaves on one of three bus arrangements. In the full-rate arrangement, every sample appears on bus A one clock after it arrives. In the two split arrangements, samples alternate between bus A (even-numbered samples counted from reset) and bus B (odd-numbered samples), so each bus runs at half rate. The two buses then either change on the same edge or take turns. Both the arrangement and the coding are read from two configuration pins only while reset is held.

The input stream uses a valid strobe and has no ready signal. A converter cannot be stalled, so the block takes every valid sample and applies no back-pressure. Each output bus has a valid strobe that pulses in the cycle its contents change. A receiver must capture the bus on that pulse or before the next pulse on the same bus. The data then holds steady between pulses.

Top module: `adc_out_fmt`

## Requirements
- R1: With `twos_sel` latched at 0, an in-range sample is output unchanged as offset binary (0x000 is negative full scale, 0x800 is zero, 0xFFF is positive full scale), and its overflow bit is 0.
- R2: With `twos_sel` latched at 1, the output code is the offset-binary code with bit 11 inverted (zero input gives 0x000, negative full scale gives 0x800).
- R3: A sample flagged by `smp_over` is output as the largest code (0xFFF offset binary, 0x7FF two's complement) with its overflow bit set to 1, whatever value `smp_code` has.
- R4: A sample flagged by `smp_under` alone is output as the smallest code (0x000 offset binary, 0x800 two's complement) with overflow 1. When both flags are set, the over-range result takes priority.
- R5: Bus arrangement codes on `bus_mode_sel` are: 0 = full rate, 1 = split with simultaneous update, 2 = split with alternating update, 3 = wide differential bus, which behaves exactly like code 0.
- R6: In full-rate arrangements, `a_valid` is high exactly one clock after each accepted sample, bus A then carries that sample, and bus B stays at zero with `b_valid` low.
- R7: In both split arrangements, the accepted samples are numbered from 0 after reset. Even-numbered samples go to bus A and odd-numbered samples go to bus B. Cycles with `smp_valid` low do not advance the count.
- R8: In the simultaneous split arrangement, one clock after each odd-numbered sample, both strobes pulse together. Bus A then holds the preceding even-numbered sample and bus B holds the odd-numbered sample.
- R9: In the alternating split arrangement, a bus updates one clock after its sample arrives, and the two strobes are never high in the same cycle.
- R10: The data and overflow bits of a bus change only in cycles where that bus's strobe is high.
- R11: `bus_mode_sel` and `twos_sel` are sampled only while `rst_n` is low. Changing them after reset has no effect on the output until the next reset.
- R12: While `rst_n` is low (synchronous, active low), all data, overflow and strobe outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| bus_mode_sel | input | 2 | Bus arrangement select (see R5) |
| twos_sel | input | 1 | 1 selects two's-complement coding, 0 selects offset binary |
| smp_valid | input | 1 | Sample strobe from the converter core |
| smp_code | input | 12 | Raw offset-binary sample |
| smp_over | input | 1 | Input was above positive full scale |
| smp_under | input | 1 | Input was below negative full scale |
| a_data | output | 12 | Bus A sample code |
| a_ovf | output | 1 | Bus A overflow bit |
| a_valid | output | 1 | Bus A update strobe |
| b_data | output | 12 | Bus B sample code |
| b_ovf | output | 1 | Bus B overflow bit |
| b_valid | output | 1 | Bus B update strobe |

## Verification
The assertions check on every cycle that bus contents hold between strobes and that strobes pair up or exclude each other as the latched arrangement demands. They also check that the full-rate strobe trails the input strobe by one clock, and that any overflowed sample carries one of the two end codes, with over-range taking priority. The exact order in which samples reach the buses, the pairing of an even sample with the following odd one, the two's-complement recoding of in-range values, and the fact that changing the configuration pins after reset has no effect can only be shown by the bench's reference model. That model tracks the sample count and the pending even sample across gaps in the input stream and across several resets.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic [1:0] {
    BUS_FULL  = 2'd0,
    BUS_SIMUL = 2'd1,
    BUS_ALT   = 2'd2,
    BUS_WIDE  = 2'd3
  } bus_mode_e;

  localparam int unsigned LANES = 2;

  function automatic logic is_full_rate(bus_mode_e m);
    return (m == BUS_FULL) || (m == BUS_WIDE);
  endfunction

endpackage

// File: rtl/adc_cfg_latch.sv
module adc_cfg_latch
  import adc_fmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] mode_pin,
  input  logic      twos_pin,
  output bus_mode_e mode_q,
  output logic      twos_q
);

  // Configuration follows the pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= bus_mode_e'(mode_pin);
      twos_q <= twos_pin;
    end
  end

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] raw_code,
  input  logic          over,
  input  logic          under,
  input  logic          twos,
  output logic [DW-1:0] fmt_code,
  output logic          fmt_ovf
);

  localparam logic [DW-1:0] TOP_CODE = {DW{1'b1}};
  localparam logic [DW-1:0] BOT_CODE = '0;
  localparam logic [DW-1:0] MSB_MASK = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] clamped;

  always_comb begin
    if (over)       clamped = TOP_CODE;
    else if (under) clamped = BOT_CODE;
    else            clamped = raw_code;
    fmt_code = twos ? (clamped ^ MSB_MASK) : clamped;
    fmt_ovf  = over | under;
  end

endmodule

// File: rtl/adc_bus_demux.sv
module adc_bus_demux
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_mode_e     mode,
  input  logic          in_vld,
  input  logic [DW-1:0] in_code,
  input  logic          in_ovf,
  output logic [DW-1:0] a_code,
  output logic          a_ovf,
  output logic          a_vld,
  output logic [DW-1:0] b_code,
  output logic          b_ovf,
  output logic          b_vld
);

  localparam int unsigned WW = DW + 1;

  logic          odd_q;
  logic [WW-1:0] park_q;
  logic [WW-1:0] cur_w;
  logic [WW-1:0] lane_nxt [LANES];
  logic          lane_ld  [LANES];
  logic [WW-1:0] lane_q   [LANES];
  logic          lane_v   [LANES];

  assign cur_w = {in_ovf, in_code};

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_ld[i]  = 1'b0;
      lane_nxt[i] = cur_w;
    end
    if (in_vld) begin
      unique case (mode)
        BUS_SIMUL: begin
          if (odd_q) begin
            lane_ld[0]  = 1'b1;
            lane_ld[1]  = 1'b1;
            lane_nxt[0] = park_q;
          end
        end
        BUS_ALT: begin
          if (odd_q) lane_ld[1] = 1'b1;
          else       lane_ld[0] = 1'b1;
        end
        default: lane_ld[0] = 1'b1;
      endcase
    end
  end

  // Sample parity and the parked even sample.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_q  <= 1'b0;
      park_q <= '0;
    end else if (in_vld && !is_full_rate(mode)) begin
      odd_q <= ~odd_q;
      if (!odd_q) park_q <= cur_w;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
        lane_v[g] <= 1'b0;
      end else begin
        lane_v[g] <= lane_ld[g];
        if (lane_ld[g]) lane_q[g] <= lane_nxt[g];
      end
    end
  end

  assign {a_ovf, a_code} = lane_q[0];
  assign {b_ovf, b_code} = lane_q[1];
  assign a_vld = lane_v[0];
  assign b_vld = lane_v[1];

endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_mode_sel,
  input  logic          twos_sel,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_code,
  input  logic          smp_over,
  input  logic          smp_under,
  output logic [DW-1:0] a_data,
  output logic          a_ovf,
  output logic          a_valid,
  output logic [DW-1:0] b_data,
  output logic          b_ovf,
  output logic          b_valid
);

  bus_mode_e     cfg_mode;
  logic          cfg_twos;
  logic [DW-1:0] f_code;
  logic          f_ovf;

  adc_cfg_latch u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_pin (bus_mode_sel),
    .twos_pin (twos_sel),
    .mode_q   (cfg_mode),
    .twos_q   (cfg_twos)
  );

  adc_code_fmt #(.DW(DW)) u_fmt (
    .raw_code (smp_code),
    .over     (smp_over),
    .under    (smp_under),
    .twos     (cfg_twos),
    .fmt_code (f_code),
    .fmt_ovf  (f_ovf)
  );

  adc_bus_demux #(.DW(DW)) u_dmx (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (cfg_mode),
    .in_vld  (smp_valid),
    .in_code (f_code),
    .in_ovf  (f_ovf),
    .a_code  (a_data),
    .a_ovf   (a_ovf),
    .a_vld   (a_valid),
    .b_code  (b_data),
    .b_ovf   (b_ovf),
    .b_vld   (b_valid)
  );

endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic          cfg_twos,
  input logic          smp_valid,
  input logic          smp_over,
  input logic          smp_under,
  input logic [DW-1:0] a_data,
  input logic          a_ovf,
  input logic          a_valid,
  input logic [DW-1:0] b_data,
  input logic          b_ovf,
  input logic          b_valid
);

  localparam logic [DW-1:0] MSB_MASK = {1'b1, {(DW-1){1'b0}}};
  logic [DW-1:0] hi_code, lo_code;
  logic          full_m;

  assign hi_code = cfg_twos ? ~MSB_MASK : {DW{1'b1}};
  assign lo_code = cfg_twos ? MSB_MASK : '0;
  assign full_m  = (cfg_mode == 2'd0) || (cfg_mode == 2'd3);

  assert_a_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |-> $stable({a_ovf, a_data}));

  assert_b_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !b_valid |-> $stable({b_ovf, b_data}));

  assert_alt_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2) |-> !(a_valid && b_valid));

  assert_simul_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1) |-> (a_valid == b_valid));

  assert_full_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_m |-> (!b_valid && (a_valid == ($past(smp_valid) && $past(rst_n)))));

  assert_end_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ovf) |-> ((a_data == hi_code) || (a_data == lo_code)));

  assert_over_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_m && $past(rst_n) && $past(smp_valid && smp_over && smp_under))
      |-> (a_ovf && (a_data == hi_code)));

endmodule

bind adc_out_fmt adc_out_fmt_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mode  (cfg_mode),
  .cfg_twos  (cfg_twos),
  .smp_valid (smp_valid),
  .smp_over  (smp_over),
  .smp_under (smp_under),
  .a_data    (a_data),
  .a_ovf     (a_ovf),
  .a_valid   (a_valid),
  .b_data    (b_data),
  .b_ovf     (b_ovf),
  .b_valid   (b_valid)
);

// File: tb/adc_out_fmt_tb_top.sv
module adc_out_fmt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_mode_sel = 2'd0;
  logic        twos_sel = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_code = '0;
  logic        smp_over = 1'b0;
  logic        smp_under = 1'b0;
  logic [11:0] a_data, b_data;
  logic        a_ovf, a_valid, b_ovf, b_valid;

  always #2 clk = ~clk;

  adc_out_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode_sel(bus_mode_sel), .twos_sel(twos_sel),
    .smp_valid(smp_valid), .smp_code(smp_code), .smp_over(smp_over),
    .smp_under(smp_under), .a_data(a_data), .a_ovf(a_ovf), .a_valid(a_valid),
    .b_data(b_data), .b_ovf(b_ovf), .b_valid(b_valid)
  );

  int vectors = 0;
  int misses = 0;
  string tag = "R12";
  int e_ad, e_ao, e_av, e_bd, e_bo, e_bv;
  int m_mode, m_twos, idx;
  int parked[$];
  int lcg = 32'h1234_5678;

  function automatic int fmt_ref(int code, int ov, int un, int tw);
    int v;
    v = ov ? 4095 : (un ? 0 : code);
    if (tw != 0) v = v ^ 2048;
    return ((ov | un) << 12) | v;
  endfunction

  task automatic model_edge();
    int s, p;
    if (!rst_n) begin
      m_mode = bus_mode_sel; m_twos = twos_sel;
      e_ad = 0; e_ao = 0; e_av = 0; e_bd = 0; e_bo = 0; e_bv = 0;
      idx = 0; parked.delete();
    end else begin
      e_av = 0; e_bv = 0;
      if (smp_valid) begin
        s = fmt_ref(smp_code, smp_over, smp_under, m_twos);
        if (m_mode == 1) begin
          if (idx % 2 == 0) parked.push_back(s);
          else begin
            p = parked.pop_front();
            e_ad = p & 4095; e_ao = p >> 12; e_av = 1;
            e_bd = s & 4095; e_bo = s >> 12; e_bv = 1;
          end
          idx++;
        end else if (m_mode == 2) begin
          if (idx % 2 == 0) begin e_ad = s & 4095; e_ao = s >> 12; e_av = 1; end
          else begin e_bd = s & 4095; e_bo = s >> 12; e_bv = 1; end
          idx++;
        end else begin
          e_ad = s & 4095; e_ao = s >> 12; e_av = 1;
        end
      end
    end
  endtask

  task automatic compare();
    vectors++;
    if (a_data !== 12'(e_ad) || a_ovf !== 1'(e_ao) || a_valid !== 1'(e_av) ||
        b_data !== 12'(e_bd) || b_ovf !== 1'(e_bo) || b_valid !== 1'(e_bv)) begin
      misses++;
      $display("FAIL %s: A=%h/%0d/%0d B=%h/%0d/%0d expected A=%h/%0d/%0d B=%h/%0d/%0d",
               tag, a_data, a_ovf, a_valid, b_data, b_ovf, b_valid,
               e_ad, e_ao, e_av, e_bd, e_bo, e_bv);
    end
  endtask

  task automatic step(input logic v, input int code, input logic ov, input logic un);
    smp_valid = v; smp_code = 12'(code); smp_over = ov; smp_under = un;
    @(posedge clk); #1; model_edge();
    @(negedge clk); compare();
  endtask

  task automatic do_reset(input int mode, input logic tw);
    tag = "R12";
    rst_n = 1'b0; bus_mode_sel = 2'(mode); twos_sel = tw;
    for (int i = 0; i < 3; i++) step(1'b1, 12'h5A5, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic corners();
    step(1, 12'h800, 0, 0); step(1, 12'hFFF, 0, 0); step(1, 12'h000, 0, 0);
    step(1, 12'h801, 0, 0); step(0, 12'h123, 0, 0); step(1, 12'h7FF, 0, 0);
    step(1, 12'h3C4, 1, 0); step(1, 12'h3C4, 0, 1); step(1, 12'h456, 1, 1);
    step(0, 12'h000, 1, 0); step(1, 12'h001, 0, 0);
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      lcg = lcg * 1103515245 + 12345;
      step(((lcg >>> 9) & 3) != 0, (lcg >>> 4) & 4095,
           ((lcg >>> 20) & 15) == 0, ((lcg >>> 24) & 15) == 1);
    end
  endtask

  initial begin
    #100000;
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R12 reset state, then R1/R3/R4/R5/R6 in full rate offset binary
    do_reset(0, 1'b0);
    tag = "R1";  corners();
    tag = "R6";  burst(40);
    // R2 two's complement coding
    do_reset(0, 1'b1);
    tag = "R2";  corners(); burst(30);
    // R5 code 3 behaves as full rate
    do_reset(3, 1'b0);
    tag = "R5";  corners(); burst(30);
    // R7/R8 simultaneous split, with gaps; R10 holding
    do_reset(1, 1'b0);
    tag = "R8";  corners(); burst(60);
    do_reset(1, 1'b1);
    tag = "R7";  burst(60);
    // R9 alternating split; R10 holding
    do_reset(2, 1'b0);
    tag = "R9";  corners(); burst(60);
    tag = "R10"; step(0, 0, 0, 0); step(0, 0, 0, 0); step(1, 12'hABC, 0, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R11 pins change after reset: no effect
    do_reset(2, 1'b1);
    tag = "R11"; bus_mode_sel = 2'd0; twos_sel = 1'b0;
    corners(); burst(40);
    bus_mode_sel = 2'd1; burst(20);
    // R3/R4 end codes in two's complement split
    do_reset(1, 1'b1);
    tag = "R3";  step(1, 12'h111, 1, 0); step(1, 12'h222, 0, 1);
    tag = "R4";  step(1, 12'h333, 1, 1); step(1, 12'h444, 0, 1); step(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule